// File: doc/BRIEF.md
# Frame-to-Vsync Alignment Loss Detector

This block watches two single-cycle pulses on the reference clock: the internal top-of-frame marker produced by the local timing generator and the Vsync pulse arriving from outside. It counts the reference-clock cycles that separate the two. It raises a status flag when that separation is larger than a programmable tolerance. Either pulse may come first. Counting starts on whichever pulse arrives first and stops when the other one arrives.

The tolerance is programmed as a 3-bit exponent, not as a cycle count. A code of n gives a tolerance of 2^n reference-clock cycles, so one small field covers every tolerance from 1 to 128 cycles. The flag is evaluated again for every frame. If the separation grows past the tolerance before the second pulse has arrived, the flag rises at once and does not wait for the measurement to close. The block only reports the state of alignment. It does not correct it.

Top module: `lossalign_window`

## Requirements
- R1: While `rst_n` is low at a clock edge, `lost_o` is 0 after that edge. After reset the window code is 3'b010, so the tolerance is 4 cycles.
- R2: A write (`cfg_we_i`=1) stores `cfg_wdata_i` as window code n at that edge. Measurements after the write use a tolerance of 2^n cycles; code 0 gives 1 cycle and code 7 gives 128 cycles.
- R3: When the frame marker is sampled at edge E0 and Vsync at edge Ek (k≥1, with no further pulses in between), then after edge Ek `lost_o` equals (k > 2^n).
- R4: When Vsync comes first and the frame marker follows k edges later, the result is the same as in R3: after the closing edge `lost_o` equals (k > 2^n).
- R5: When both pulses are sampled at the same edge while no measurement is open, the separation is 0 and `lost_o` is 0 after that edge.
- R6: Once one pulse has opened a measurement at E0 and the other has not yet arrived, `lost_o` is still unchanged after edge E(2^n) and is 1 after edge E(2^n+1).
- R7: A late closing pulse leaves `lost_o` at 1. A later frame whose separation is within the tolerance clears it. While no measurement is open and no pulse arrives, `lost_o` holds its value.
- R8: The separation counter saturates and does not wrap. A pulse that closes a measurement after 600 cycles, with code 7, still leaves `lost_o` at 1.
- R9: If the same pulse that opened a measurement repeats before the other pulse arrives, the measurement restarts from that repeat. A closing pulse sampled in the same cycle as the repeat takes priority and closes the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_mark_i | input | 1 | Internal top-of-frame pulse, one cycle wide |
| vsync_i | input | 1 | External Vsync pulse, one cycle wide |
| cfg_we_i | input | 1 | Write strobe for the window code |
| cfg_wdata_i | input | 3 | Window code n; the tolerance is 2^n cycles |
| lost_o | output | 1 | Loss-of-alignment status |

## Verification
The assertions assume that both event inputs are pulses already synchronous to the reference clock. They also assume that a window write lands between measurements or while a measurement is open, and that the new tolerance simply applies from the next edge on. The stimulus drives every pulse for exactly one cycle, changes inputs only on falling edges, and spaces the scenarios with idle cycles so that each measurement closes before the next one opens. The restart and priority scenario is the one exception: there a repeat pulse is placed deliberately.

// File: rtl/lossalign_pkg.sv
// Package: shared types for the alignment loss detector.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package lossalign_pkg;
    // Which event opened the current measurement, if any.
    typedef enum logic [1:0] {
        MS_IDLE    = 2'd0,
        MS_WAIT_VS = 2'd1,
        MS_WAIT_FM = 2'd2
    } meas_state_e;
endpackage

// File: rtl/lossalign_cfg.sv
// Module: lossalign_cfg
// Holds the window exponent and decodes it into a one-hot cycle threshold.
// Assumes: CNT_W > 2**WIN_W, so that the top bit of the threshold is always zero.
module lossalign_cfg #(
    parameter int WIN_W = 3,
    parameter int CNT_W = 9,
    parameter logic [WIN_W-1:0] WIN_RST = 3'b010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIN_W-1:0] wdata_i,
    output logic [CNT_W-1:0] thr_o
);
    localparam int NCODES = 1 << WIN_W;

    logic [WIN_W-1:0] code_q;

    // Store the window exponent on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= WIN_RST;
        end else if (we_i) begin
            code_q <= wdata_i;
        end
    end

    // Decode the exponent into a power-of-two threshold, one bit per code.
    for (genvar i = 0; i < NCODES; i++) begin : g_dec
        assign thr_o[i] = (code_q == WIN_W'(i));
    end
    for (genvar j = NCODES; j < CNT_W; j++) begin : g_pad
        assign thr_o[j] = 1'b0;
    end
endmodule

// File: rtl/lossalign_meas.sv
// Module: lossalign_meas
// Measures the cycle distance between the frame marker and Vsync, whichever comes first.
// Assumes: both inputs are single-cycle pulses synchronous to clk.
module lossalign_meas
    import lossalign_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fm_i,
    input  logic             vs_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o,
    output logic [CNT_W-1:0] diff_o
);
    meas_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Saturating increment of the distance counter.
    always_comb begin
        cnt_inc = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + CNT_W'(1);
    end

    // Open, extend, restart or close the measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                MS_IDLE: begin
                    if (fm_i && vs_i) begin
                        cnt_q <= '0;
                    end else if (fm_i) begin
                        state_q <= MS_WAIT_VS;
                        cnt_q   <= CNT_W'(1);
                    end else if (vs_i) begin
                        state_q <= MS_WAIT_FM;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                MS_WAIT_VS: begin
                    if (vs_i) begin
                        state_q <= MS_IDLE;
                        cnt_q   <= '0;
                    end else if (fm_i) begin
                        cnt_q <= CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_inc;
                    end
                end
                MS_WAIT_FM: begin
                    if (fm_i) begin
                        state_q <= MS_IDLE;
                        cnt_q   <= '0;
                    end else if (vs_i) begin
                        cnt_q <= CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_inc;
                    end
                end
                default: begin
                    state_q <= MS_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Report the closing event and the measured distance.
    always_comb begin
        busy_o = (state_q != MS_IDLE);
        cnt_o  = cnt_q;
        done_o = ((state_q == MS_IDLE) && fm_i && vs_i) ||
                 ((state_q == MS_WAIT_VS) && vs_i) ||
                 ((state_q == MS_WAIT_FM) && fm_i);
        diff_o = (state_q == MS_IDLE) ? '0 : cnt_q;
    end
endmodule

// File: rtl/lossalign_flag.sv
// Module: lossalign_flag
// Turns the measured distance and the running count into the loss status.
// Assumes: done_i is a single-cycle pulse, and diff_i is valid while it is high.
module lossalign_flag #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [CNT_W-1:0] diff_i,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             lost_o
);
    logic lost_q;

    // Judge each closed frame, and raise early when an open count overruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost_q <= 1'b0;
        end else if (done_i) begin
            lost_q <= (diff_i > thr_i);
        end else if (busy_i && (cnt_i > thr_i)) begin
            lost_q <= 1'b1;
        end
    end

    assign lost_o = lost_q;
endmodule

// File: rtl/lossalign_window.sv
// Module: lossalign_window (top)
// Flags loss of alignment when the frame marker and Vsync differ by more than 2^n cycles.
// Assumes: all inputs are synchronous to clk; the event inputs are one-cycle pulses.
module lossalign_window #(
    parameter int WIN_W = 3,
    parameter logic [WIN_W-1:0] WIN_RST = 3'b010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_mark_i,
    input  logic             vsync_i,
    input  logic             cfg_we_i,
    input  logic [WIN_W-1:0] cfg_wdata_i,
    output logic             lost_o
);
    localparam int CNT_W = (1 << WIN_W) + 1;

    logic [CNT_W-1:0] win_thr;
    logic             meas_busy;
    logic [CNT_W-1:0] meas_cnt;
    logic             meas_done;
    logic [CNT_W-1:0] meas_diff;

    lossalign_cfg #(.WIN_W(WIN_W), .CNT_W(CNT_W), .WIN_RST(WIN_RST)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .thr_o   (win_thr)
    );

    lossalign_meas #(.CNT_W(CNT_W)) u_meas (
        .clk    (clk),
        .rst_n  (rst_n),
        .fm_i   (frame_mark_i),
        .vs_i   (vsync_i),
        .busy_o (meas_busy),
        .cnt_o  (meas_cnt),
        .done_o (meas_done),
        .diff_o (meas_diff)
    );

    lossalign_flag #(.CNT_W(CNT_W)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (meas_done),
        .diff_i (meas_diff),
        .busy_i (meas_busy),
        .cnt_i  (meas_cnt),
        .thr_i  (win_thr),
        .lost_o (lost_o)
    );
endmodule

// File: rtl/lossalign_window_chk.sv
// Module: lossalign_window_chk
// Temporal checks on the detector, attached to the top through bind.
// Assumes: it is connected to the top's ports and its internal measurement nets.
module lossalign_window_chk #(
    parameter int WIN_W = 3,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_mark_i,
    input logic             vsync_i,
    input logic             cfg_we_i,
    input logic [WIN_W-1:0] cfg_wdata_i,
    input logic             lost_o,
    input logic [CNT_W-1:0] thr,
    input logic             busy,
    input logic [CNT_W-1:0] cnt
);
    // R1: reset clears the status.
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !lost_o);

    // R2: a write sets the threshold to 2^code.
    a_r2_window_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (thr == (CNT_W'(1) << $past(cfg_wdata_i))));

    // R5: coincident events with no open measurement mean zero separation.
    a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && frame_mark_i && vsync_i) |=> !lost_o);

    // R6: an open count beyond the threshold raises the flag on the next edge.
    a_r6_early_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cnt > thr)) |=> lost_o);

    // R7: with no measurement open and no event arriving, the flag holds.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !frame_mark_i && !vsync_i) |=> $stable(lost_o));

    // R8: with no event arriving, the open count never goes down.
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_mark_i && !vsync_i) |=> (busy && (cnt >= $past(cnt))));
endmodule

bind lossalign_window lossalign_window_chk #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_mark_i (frame_mark_i),
    .vsync_i      (vsync_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .lost_o       (lost_o),
    .thr          (win_thr),
    .busy         (meas_busy),
    .cnt          (meas_cnt)
);

// File: tb/lossalign_window_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios for lossalign_window; every task checks its own results.
module lossalign_window_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_mark_i = 1'b0;
    logic       vsync_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [2:0] cfg_wdata_i = 3'd0;
    logic       lost_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    lossalign_window u_lossalign_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_mark_i (frame_mark_i),
        .vsync_i      (vsync_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .lost_o       (lost_o)
    );

    // 200 MHz reference clock.
    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lost_o=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_code(input logic [2:0] code);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_wdata_i = code;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // One measurement: the first pulse is sampled at E0, the second at Ek (k=0: same edge).
    task automatic measure(input bit fm_first, input int k);
        @(negedge clk);
        if (k == 0) begin
            frame_mark_i = 1'b1;
            vsync_i = 1'b1;
            @(negedge clk);
            frame_mark_i = 1'b0;
            vsync_i = 1'b0;
        end else begin
            if (fm_first) frame_mark_i = 1'b1; else vsync_i = 1'b1;
            @(negedge clk);
            frame_mark_i = 1'b0;
            vsync_i = 1'b0;
            repeat (k - 1) @(negedge clk);
            if (fm_first) vsync_i = 1'b1; else frame_mark_i = 1'b1;
            @(negedge clk);
            frame_mark_i = 1'b0;
            vsync_i = 1'b0;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        check("R1 reset", lost_o, 1'b0);
        rst_n = 1'b1;
        idle(2);
        check("R1 after release", lost_o, 1'b0);
    endtask

    task automatic t_default_window;
        measure(1'b1, 4); check("R1 default tol 4, k=4", lost_o, 1'b0);
        idle(2);
        measure(1'b1, 5); check("R3 fm first k=5", lost_o, 1'b1);
        idle(2);
        measure(1'b1, 2); check("R7 clear k=2", lost_o, 1'b0);
        idle(2);
    endtask

    task automatic t_vsync_first;
        measure(1'b0, 5); check("R4 vs first k=5", lost_o, 1'b1);
        idle(2);
        measure(1'b0, 4); check("R4 vs first k=4", lost_o, 1'b0);
        idle(2);
    endtask

    task automatic t_same_cycle;
        measure(1'b1, 7); check("R3 set before coincident", lost_o, 1'b1);
        idle(2);
        check("R7 hold while idle", lost_o, 1'b1);
        measure(1'b1, 0); check("R5 coincident clears", lost_o, 1'b0);
        idle(2);
    endtask

    task automatic t_early_raise;
        @(negedge clk);
        frame_mark_i = 1'b1;
        @(negedge clk);
        frame_mark_i = 1'b0;
        idle(4);
        check("R6 not yet at E4", lost_o, 1'b0);
        idle(1);
        check("R6 raised at E5", lost_o, 1'b1);
        idle(2);
        vsync_i = 1'b1;
        @(negedge clk);
        vsync_i = 1'b0;
        check("R7 late close stays set", lost_o, 1'b1);
        idle(2);
        measure(1'b1, 3); check("R7 in-window frame clears", lost_o, 1'b0);
        idle(2);
    endtask

    task automatic t_codes;
        write_code(3'd0);
        idle(1);
        measure(1'b1, 1); check("R2 code0 k=1", lost_o, 1'b0);
        idle(2);
        measure(1'b0, 2); check("R2 code0 k=2", lost_o, 1'b1);
        idle(2);
        write_code(3'd7);
        idle(1);
        measure(1'b1, 128); check("R2 code7 k=128", lost_o, 1'b0);
        idle(2);
        measure(1'b1, 129); check("R2 code7 k=129", lost_o, 1'b1);
        idle(2);
        measure(1'b0, 100); check("R2 code7 k=100", lost_o, 1'b0);
        idle(2);
    endtask

    task automatic t_saturate;
        measure(1'b1, 600); check("R8 no wrap k=600", lost_o, 1'b1);
        idle(2);
        write_code(3'd2);
        idle(1);
    endtask

    task automatic t_restart;
        // The first frame at E0 repeats at E3, and Vsync follows at E5.
        @(negedge clk);
        frame_mark_i = 1'b1;
        @(negedge clk);
        frame_mark_i = 1'b0;
        idle(2);
        frame_mark_i = 1'b1;
        @(negedge clk);
        frame_mark_i = 1'b0;
        idle(1);
        vsync_i = 1'b1;
        @(negedge clk);
        vsync_i = 1'b0;
        check("R9 restart gives distance 2", lost_o, 1'b0);
        idle(2);
        // Priority: a closing pulse in the same cycle as a repeat closes the measurement.
        measure(1'b1, 6); check("R9 set before priority case", lost_o, 1'b1);
        idle(2);
        @(negedge clk);
        vsync_i = 1'b1;
        @(negedge clk);
        vsync_i = 1'b0;
        idle(1);
        frame_mark_i = 1'b1;
        vsync_i = 1'b1;
        @(negedge clk);
        frame_mark_i = 1'b0;
        vsync_i = 1'b0;
        check("R9 close takes priority (distance 2)", lost_o, 1'b0);
        idle(8);
        check("R9 nothing left open", lost_o, 1'b0);
    endtask

    // Watchdog: an expired timer counts as a failure.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_default_window();
        t_vsync_first();
        t_same_cycle();
        t_early_raise();
        t_codes();
        t_saturate();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule